// File: doc/BRIEF.md
# Ladder Point-Multiply Sequencer

This block computes the elliptic-curve scalar product Q = k·P. It holds the running state in two working point slots and walks the scalar from its second-highest bit down to bit 0. For each bit it sends exactly one point-addition command and then exactly one point-doubling command to an external point arithmetic unit. The bit value selects which slot supplies the operands and which slot takes the result. The command sequence has the same length and shape for every scalar, so the number of cycles does not reveal the key. The field arithmetic and the add and double formulas are left to the arithmetic unit.

Each command is a one-cycle `cmd_start` pulse that comes with an opcode, two source slot indices, a destination slot index and the two operand values. The sequencer then waits for a one-cycle `au_done` pulse carrying the result. It writes that result into the destination slot and only then moves on. When the last bit is finished, the first slot is presented on `result` and `ready` pulses for one cycle. Slot index 0 is the first slot, which is loaded with P. Slot index 1 is the second slot, which receives 2P.

Top module: `ladder_pmul_seq`

## Requirements
- R1: After reset, `busy`, `ready`, `err` and `cmd_start` are all 0.
- R2: If `start` arrives in idle while `scalar[KEY_W-1]` is 0, `err` is 1 from the next cycle and `busy` stays 0. No command is issued. `err` holds until an accepted start clears it.
- R3: An accepted start sets `busy` in the next cycle, and `busy` stays 1 until completion. `ready` is a one-cycle pulse, and `busy` is already 0 in that cycle.
- R4: The first command has opcode 2'b01 (initial double), sources 0 and 0, and destination 1. Its operand is the base point.
- R5: The first command is followed by exactly one add (opcode 2'b10) and then one double (opcode 2'b11) for each bit from KEY_W-2 down to 0. A run therefore issues 2·KEY_W−1 commands, whatever the scalar value.
- R6: For a scalar bit of 1, the add has src_a=0, src_b=1, dst=0 and the double has src_a=src_b=dst=1.
- R7: For a scalar bit of 0, the add has src_a=1, src_b=0, dst=1 and the double has src_a=src_b=dst=0.
- R8: With each `cmd_start`, `cmd_opa` and `cmd_opb` carry the current contents of the slots named by `cmd_src_a` and `cmd_src_b`.
- R9: `cmd_start` is a one-cycle pulse. No new command is issued until `au_done` has returned the previous result. An `au_done` outside a wait has no effect.
- R10: At `ready`, `result` equals k·P as built from the returned add and double results. It holds that value until the next completion.
- R11: A `start` during a run is ignored, and the run completes with its original scalar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication (one cycle) |
| scalar | input | KEY_W | Scalar k, top bit must be 1 |
| base_pt | input | PT_W | Base point P |
| busy | output | 1 | Multiplication in progress |
| ready | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start rejected (top bit 0) |
| result | output | PT_W | Product point Q |
| cmd_start | output | 1 | Command strobe to arithmetic unit |
| cmd_op | output | 2 | 01 initial double, 10 add, 11 double |
| cmd_src_a | output | 1 | First source slot index |
| cmd_src_b | output | 1 | Second source slot index |
| cmd_dst | output | 1 | Destination slot index |
| cmd_opa | output | PT_W | First operand value |
| cmd_opb | output | PT_W | Second operand value |
| au_done | input | 1 | Arithmetic result valid (one cycle) |
| au_res | input | PT_W | Arithmetic result |

## Verification
The hardest situation to reach is a stray arrival: an `au_done` while no command is outstanding, or a `start` in the middle of a long run. Either one could corrupt a slot or restart the ladder without any visible sign. The bench models the arithmetic unit as integer addition and doubling modulo 2^PT_W, with a random latency, so a correct ladder must produce exactly k·P. It injects a second start partway through a run with a different scalar, and an unsolicited done with random data while idle. It then confirms that the result and the command count are unchanged.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_INIT_DBL = 2'b01,
    OP_ADD      = 2'b10,
    OP_DBL      = 2'b11
  } ladder_op_e;

  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_ADD  = 2'd1,
    PH_DBL  = 2'd2
  } ladder_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } ladder_state_e;

  typedef struct packed {
    ladder_op_e op;
    logic       src_a;
    logic       src_b;
    logic       dst;
  } ladder_cmd_t;

  // Command chosen from the ladder phase and the current scalar bit.
  function automatic ladder_cmd_t plan_cmd(input ladder_phase_e ph, input logic kbit);
    ladder_cmd_t c;
    case (ph)
      PH_INIT: c = '{op: OP_INIT_DBL, src_a: 1'b0, src_b: 1'b0, dst: 1'b1};
      PH_ADD:  c = kbit ? '{op: OP_ADD, src_a: 1'b0, src_b: 1'b1, dst: 1'b0}
                        : '{op: OP_ADD, src_a: 1'b1, src_b: 1'b0, dst: 1'b1};
      default: c = kbit ? '{op: OP_DBL, src_a: 1'b1, src_b: 1'b1, dst: 1'b1}
                        : '{op: OP_DBL, src_a: 1'b0, src_b: 1'b0, dst: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ladder_scan.sv
module ladder_scan #(
  parameter int KEY_W = 163
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] scalar_in,
  input  logic             step,
  output logic             cur_bit,
  output logic             last_bit
);
  localparam int IDX_W = $clog2(KEY_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(KEY_W - 2);

  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      key_q <= scalar_in;
      idx_q <= IDX_TOP;
    end else if (step) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  assign cur_bit  = key_q[idx_q];
  assign last_bit = (idx_q == '0);

  // R5: the index never steps below bit 0.
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    step |-> !last_bit);

  // R11: a loaded scalar stays put until the next load.
  p_key_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(key_q));

endmodule

// File: rtl/ladder_slots.sv
module ladder_slots #(
  parameter int PT_W = 326
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_base,
  input  logic [PT_W-1:0] base_pt,
  input  logic            wr_en,
  input  logic            wr_dst,
  input  logic [PT_W-1:0] wr_data,
  input  logic            issue,
  input  logic            rd_a,
  input  logic            rd_b,
  input  logic            capture,
  output logic [PT_W-1:0] opa,
  output logic [PT_W-1:0] opb,
  output logic [PT_W-1:0] result
);
  localparam int NSLOT = 2;

  logic [PT_W-1:0] slot_q [NSLOT];
  logic [PT_W-1:0] opa_q, opb_q, res_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (load_base && g == 0)
        slot_q[g] <= base_pt;
      else if (wr_en && wr_dst == 1'(g))
        slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      if (issue) begin
        opa_q <= slot_q[rd_a];
        opb_q <= slot_q[rd_b];
      end
      if (capture)
        res_q <= slot_q[0];
    end
  end

  assign opa    = opa_q;
  assign opb    = opb_q;
  assign result = res_q;

  // R9: loading P and writing a result never collide.
  p_no_wr_clash_r9: assert property (@(posedge clk) disable iff (rst)
    !(load_base && wr_en));

  // R10: the result register changes only after a capture.
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(res_q));

endmodule

// File: rtl/ladder_ctrl.sv
module ladder_ctrl
  import ladder_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        msb,
  input  logic        au_done,
  input  logic        cur_bit,
  input  logic        last_bit,
  output logic        scan_load,
  output logic        scan_step,
  output logic        slot_load,
  output logic        slot_wr,
  output logic        issue,
  output logic        capture,
  output ladder_cmd_t next_cmd,
  output ladder_cmd_t cmd,
  output logic        cmd_start,
  output logic        busy,
  output logic        ready,
  output logic        err
);
  ladder_state_e state_q;
  ladder_phase_e phase_q;
  ladder_cmd_t   cmd_q;
  logic          start_q, busy_q, ready_q, err_q;

  logic accept;

  assign accept    = (state_q == ST_IDLE) && start && msb;
  assign scan_load = accept;
  assign slot_load = accept;
  assign issue     = (state_q == ST_ISSUE);
  assign next_cmd  = plan_cmd(phase_q, cur_bit);
  assign slot_wr   = (state_q == ST_WAIT) && au_done;
  assign scan_step = slot_wr && (phase_q == PH_DBL) && !last_bit;
  assign capture   = (state_q == ST_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_INIT;
      cmd_q   <= '{op: OP_NONE, src_a: 1'b0, src_b: 1'b0, dst: 1'b0};
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      ready_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (msb) begin
              err_q   <= 1'b0;
              busy_q  <= 1'b1;
              phase_q <= PH_INIT;
              state_q <= ST_ISSUE;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_ISSUE: begin
          cmd_q   <= next_cmd;
          start_q <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (au_done) begin
            case (phase_q)
              PH_INIT: begin
                phase_q <= PH_ADD;
                state_q <= ST_ISSUE;
              end
              PH_ADD: begin
                phase_q <= PH_DBL;
                state_q <= ST_ISSUE;
              end
              default: begin
                if (last_bit) begin
                  state_q <= ST_FINISH;
                end else begin
                  phase_q <= PH_ADD;
                  state_q <= ST_ISSUE;
                end
              end
            endcase
          end
        end
        default: begin
          ready_q <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign cmd       = cmd_q;
  assign cmd_start = start_q;
  assign busy      = busy_q;
  assign ready     = ready_q;
  assign err       = err_q;

  // R9: one-cycle command strobe.
  p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

  // R3: commands only go out during a run.
  p_cmd_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> busy);

  // R3: completion pulse is single-cycle and follows the end of busy.
  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  p_ready_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);

  // R2: a rejected start leaves the sequencer quiet.
  p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !cmd_start));

  // R11: a start while busy does not reload the scalar.
  p_no_reload_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !scan_load);

endmodule

// File: rtl/ladder_pmul_seq.sv
module ladder_pmul_seq
  import ladder_pkg::*;
#(
  parameter int KEY_W = 163,
  parameter int PT_W  = 326
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] scalar,
  input  logic [PT_W-1:0]  base_pt,
  output logic             busy,
  output logic             ready,
  output logic             err,
  output logic [PT_W-1:0]  result,
  output logic             cmd_start,
  output logic [1:0]       cmd_op,
  output logic             cmd_src_a,
  output logic             cmd_src_b,
  output logic             cmd_dst,
  output logic [PT_W-1:0]  cmd_opa,
  output logic [PT_W-1:0]  cmd_opb,
  input  logic             au_done,
  input  logic [PT_W-1:0]  au_res
);
  logic        scan_load, scan_step, slot_load, slot_wr, issue, capture;
  logic        cur_bit, last_bit;
  ladder_cmd_t next_cmd, cmd;

  ladder_scan #(.KEY_W(KEY_W)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .load     (scan_load),
    .scalar_in(scalar),
    .step     (scan_step),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  ladder_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .msb      (scalar[KEY_W-1]),
    .au_done  (au_done),
    .cur_bit  (cur_bit),
    .last_bit (last_bit),
    .scan_load(scan_load),
    .scan_step(scan_step),
    .slot_load(slot_load),
    .slot_wr  (slot_wr),
    .issue    (issue),
    .capture  (capture),
    .next_cmd (next_cmd),
    .cmd      (cmd),
    .cmd_start(cmd_start),
    .busy     (busy),
    .ready    (ready),
    .err      (err)
  );

  ladder_slots #(.PT_W(PT_W)) u_slots (
    .clk      (clk),
    .rst      (rst),
    .load_base(slot_load),
    .base_pt  (base_pt),
    .wr_en    (slot_wr),
    .wr_dst   (cmd.dst),
    .wr_data  (au_res),
    .issue    (issue),
    .rd_a     (next_cmd.src_a),
    .rd_b     (next_cmd.src_b),
    .capture  (capture),
    .opa      (cmd_opa),
    .opb      (cmd_opb),
    .result   (result)
  );

  assign cmd_op    = cmd.op;
  assign cmd_src_a = cmd.src_a;
  assign cmd_src_b = cmd.src_b;
  assign cmd_dst   = cmd.dst;

  // R6/R7: an add always combines both slots and writes its first source.
  p_add_slots_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_op == OP_ADD) |-> (cmd_src_a != cmd_src_b && cmd_dst == cmd_src_a));

  // R7: a double reads and writes a single slot.
  p_dbl_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_op == OP_DBL) |-> (cmd_src_a == cmd_src_b && cmd_dst == cmd_src_a));

  // R4: the initial double takes slot 0 into slot 1.
  p_init_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_op == OP_INIT_DBL) |-> (!cmd_src_a && !cmd_src_b && cmd_dst));

  // R8: the double's two operands are the same value.
  p_dbl_operands_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_op != OP_ADD) |-> (cmd_opa == cmd_opb));

endmodule

// File: tb/ladder_pmul_seq_bench.sv
module ladder_pmul_seq_bench;
  localparam int KW = 163;
  localparam int PW = 64;
  localparam int NCMD = 2 * KW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic [PW-1:0] base_pt = '0;
  logic          busy, ready, err, cmd_start;
  logic [PW-1:0] result, cmd_opa, cmd_opb;
  logic [1:0]    cmd_op;
  logic          cmd_src_a, cmd_src_b, cmd_dst;
  logic          au_done = 1'b0;
  logic [PW-1:0] au_res = '0;

  ladder_pmul_seq #(.KEY_W(KW), .PT_W(PW)) u_ladder_pmul_seq (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar), .base_pt(base_pt),
    .busy(busy), .ready(ready), .err(err), .result(result),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_src_a(cmd_src_a),
    .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst), .cmd_opa(cmd_opa),
    .cmd_opb(cmd_opb), .au_done(au_done), .au_res(au_res)
  );

  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int ncmd = 0;
  int cyc  = 0;
  logic          outstanding = 1'b0;
  logic          stray = 1'b0;
  logic [KW-1:0] cur_k = '0;
  logic [PW-1:0] mir0 = '0, mir1 = '0;

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mul_ref(input logic [KW-1:0] k, input logic [PW-1:0] p);
    logic [PW-1:0] acc = '0;
    for (int i = 0; i < KW; i++)
      if (k[i]) acc = acc + (p << i);
    return acc;
  endfunction

  // Arithmetic unit model: add = a+b, double = 2a, with random latency.
  initial begin
    int            cnt = 0;
    logic [PW-1:0] pend = '0;
    logic          pdst = 1'b0;
    forever begin
      @(negedge clk);
      au_done = 1'b0;
      if (stray) begin
        au_done = 1'b1;
        au_res  = {$urandom, $urandom};
        stray   = 1'b0;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          au_done = 1'b1;
          au_res  = pend;
          outstanding = 1'b0;
          if (pdst) mir1 = pend; else mir0 = pend;
        end
      end
      if (cmd_start) begin
        logic [1:0]    eop;
        logic          eb, ea, ebb, ed;
        logic [PW-1:0] ma, mb;
        string         rq;
        int            bi;
        chk(!outstanding, "R9 command before done", PW'(outstanding), '0);
        if (ncmd == 0) begin
          eop = 2'b01; ea = 1'b0; ebb = 1'b0; ed = 1'b1; rq = "R4 init command";
        end else begin
          bi = KW - 1 - ((ncmd + 1) / 2);
          eb = cur_k[bi];
          if (ncmd % 2 == 1) begin
            eop = 2'b10;
            if (eb) begin ea = 1'b0; ebb = 1'b1; ed = 1'b0; end
            else    begin ea = 1'b1; ebb = 1'b0; ed = 1'b1; end
          end else begin
            eop = 2'b11; ea = ~eb; ebb = ~eb; ed = ~eb;
            ea = eb; ebb = eb; ed = eb;
          end
          rq = eb ? "R6/R5 bit-one command" : "R7/R5 bit-zero command";
        end
        chk({cmd_op, cmd_src_a, cmd_src_b, cmd_dst} == {eop, ea, ebb, ed}, rq,
            PW'({cmd_op, cmd_src_a, cmd_src_b, cmd_dst}), PW'({eop, ea, ebb, ed}));
        ma = cmd_src_a ? mir1 : mir0;
        mb = cmd_src_b ? mir1 : mir0;
        chk(cmd_opa == ma && cmd_opb == mb, "R8 operand values", cmd_opa ^ cmd_opb, ma ^ mb);
        pend = (cmd_op == 2'b10) ? (cmd_opa + cmd_opb) : (cmd_opa << 1);
        pdst = cmd_dst;
        outstanding = 1'b1;
        cnt = 1 + int'($urandom % 4);
        ncmd++;
      end
    end
  end

  task automatic run_one(input logic [KW-1:0] k, input logic [PW-1:0] p, input bit mid_start);
    logic [PW-1:0] exp;
    bit            busy_ok = 1'b1;
    bit            done = 1'b0;
    exp = mul_ref(k, p);
    cur_k = k; mir0 = p; ncmd = 0;
    @(negedge clk);
    start = 1'b1; scalar = k; base_pt = p;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", PW'(busy), 1);
    chk(err == 1'b0, "R2 err cleared by accepted start", PW'(err), 0);
    for (int i = 0; i < 5000; i++) begin
      if (mid_start && i == 60) begin
        start = 1'b1; scalar = ~k | {1'b1, {(KW-1){1'b0}}}; base_pt = ~p;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (ready) begin done = 1'b1; break; end
      if (!busy) busy_ok = 1'b0;
    end
    start = 1'b0;
    chk(done, "R3 ready reached", PW'(done), 1);
    chk(busy_ok, "R3 busy held during run", PW'(busy_ok), 1);
    chk(busy == 1'b0, "R3 busy low at ready", PW'(busy), 0);
    chk(result == exp, mid_start ? "R11 result after mid-run start" : "R10 product", result, exp);
    chk(ncmd == NCMD, "R5 command count", PW'(ncmd), PW'(NCMD));
    @(negedge clk);
    chk(ready == 1'b0, "R3 ready single cycle", PW'(ready), 0);
    chk(result == exp, "R10 result held", result, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [KW-1:0] k;
    logic [PW-1:0] r0;
    int            c0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, ready, err, cmd_start} == 4'b0, "R1 reset state",
        PW'({busy, ready, err, cmd_start}), 0);

    // R2: top bit 0 is rejected.
    ncmd = 0;
    start = 1'b1; scalar = {1'b0, {(KW-1){1'b1}}}; base_pt = 64'h5;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R2 err on zero top bit", PW'({err, busy}), 64'h2);
    repeat (10) @(negedge clk);
    chk(ncmd == 0 && err == 1'b1, "R2 no commands, err held", PW'(ncmd), 0);

    // Directed corner scalars.
    run_one({KW{1'b1}}, 64'h3, 1'b0);
    run_one({1'b1, {(KW-1){1'b0}}}, 64'h1234_5678_9abc_def1, 1'b0);
    k = '0;
    for (int i = 0; i < KW; i++) k[i] = i[0];
    k[KW-1] = 1'b1;
    run_one(k, 64'hffff_ffff_ffff_fffb, 1'b0);
    run_one({1'b1, {(KW-2){1'b0}}, 1'b1}, 64'h7, 1'b1);

    // Random scalars and points.
    for (int t = 0; t < 9; t++) begin
      for (int w = 0; w < KW; w += 32) k[w +: 32] = $urandom;
      k[KW-1] = 1'b1;
      run_one(k, {$urandom, $urandom}, (t == 4));
    end

    // R9: an unsolicited done while idle changes nothing.
    r0 = result; c0 = ncmd;
    stray = 1'b1;
    repeat (4) @(negedge clk);
    chk(result == r0 && ncmd == c0 && !busy && !cmd_start, "R9 stray done ignored", result, r0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule